// File: doc/BRIEF.md
# Stack Pointer and Address Unit

This block owns the 16-bit stack pointer of a small 8-bit processor and produces every address that a stack access needs. An instruction sequencer hands it one operation at a time: push or pull a single byte, move the pointer by a signed amount to open or release room for local variables, form a pointer-relative address with a short (8-bit) or long (16-bit) unsigned offset, restore the low byte of the pointer, or exchange the pointer with the 16-bit index register. The data memory sits outside. The block presents the address together with a write or read strobe, and it returns the byte read on a pull along with the register it is bound for.

The pointer always names the next free byte. The stack grows toward lower addresses. A push therefore writes first and decrements afterwards. A pull increments first and then reads. Copying the pointer into the index register yields pointer + 1, so the index lands on the most recently pushed byte. The opposite copy stores index − 1. All arithmetic wraps modulo 2^16 and raises no fault.

A state machine controls the block. `ST_IDLE` is the only state that accepts an operation. On acceptance it branches to one of these states: `ST_PUSH` (write, then decrement), `ST_PULL_BUMP` (increment), `ST_ADJUST`, `ST_REL_SHORT`, `ST_REL_LONG`, `ST_RSP`, `ST_TO_IDX` or `ST_FROM_IDX`. Each of these returns to `ST_IDLE` after one cycle. The one exception is `ST_PULL_BUMP`, which continues to `ST_PULL_READ` (read) and only then returns to `ST_IDLE`. Codes that are not defined leave the machine in `ST_IDLE`.

Top module: `stack_addr_unit`

## Requirements
- R1: After power-on reset, `sp_out` is 0x00FF, `op_ready` is 1 and no strobe (`mem_wr`, `mem_rd`, `ea_valid`, `idx_valid`) is active. Reset can be applied at any time and always restores the full value 0x00FF.
- R2: Push (op_code 0) produces, one cycle after acceptance, `mem_wr`=1 with `mem_addr` equal to the pointer before the push. `mem_wdata` is the byte picked by `reg_sel`: 0 picks acc_in, 1 picks idx_in[15:8], 2 or 3 picks idx_in[7:0]. After that cycle the pointer has dropped by one.
- R3: Pull (op_code 1) first raises the pointer by one. In the second cycle after acceptance it drives `mem_rd`=1 and `pull_valid`=1, with `mem_addr` equal to the new pointer, `pull_data` equal to `mem_rdata` and `pull_dst` equal to the accepted `reg_sel`.
- R4: Adjust (op_code 2) adds `imm8`, sign-extended, to the pointer. 0xF0 opens 16 bytes and 0x10 releases them.
- R5: Short relative (op_code 3) drives `ea_valid`=1 for one cycle with `mem_addr` equal to the pointer plus `imm8` zero-extended. The pointer does not change.
- R6: Long relative (op_code 4) drives `ea_valid`=1 with `mem_addr` equal to the pointer plus `off16`. The pointer does not change.
- R7: Low-byte restore (op_code 5) sets pointer bits [7:0] to 0xFF and leaves bits [15:8] unchanged.
- R8: Pointer-to-index (op_code 6) drives `idx_valid`=1 with `idx_out` equal to the pointer + 1. The pointer does not change.
- R9: Index-to-pointer (op_code 7) loads the pointer with `idx_in` − 1.
- R10: Every pointer and address result wraps modulo 2^16.
- R11: A sequence of pushes followed by the same number of pulls returns the bytes in last-in-first-out order and restores the original pointer.
- R12: `op_ready` is 1 only in `ST_IDLE`. While it is 0, `op_valid` has no effect. Codes 8 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when op_ready is 1 |
| op_code | input | 4 | Operation code (see R2 to R9) |
| reg_sel | input | 2 | Byte source for a push, destination tag for a pull |
| imm8 | input | 8 | Signed adjust amount or short unsigned offset |
| off16 | input | 16 | Long unsigned offset |
| acc_in | input | 8 | Accumulator value |
| idx_in | input | 16 | Index register value |
| op_ready | output | 1 | Block is idle and accepts an operation |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Address of the access in progress |
| mem_wr | output | 1 | Push write strobe |
| mem_rd | output | 1 | Pull read strobe |
| mem_wdata | output | 8 | Byte to write on a push |
| mem_rdata | input | 8 | Byte returned by memory for mem_addr |
| ea_valid | output | 1 | mem_addr carries a pointer-relative address |
| pull_valid | output | 1 | pull_data is valid |
| pull_data | output | 8 | Pulled byte |
| pull_dst | output | 2 | Destination register of the pulled byte |
| idx_valid | output | 1 | idx_out is valid |
| idx_out | output | 16 | Value for the index register |

## Verification
The bench builds the block with its default parameters: a 16-bit pointer, 8-bit data, a 16-bit long offset and a reset value of 0x00FF. Because the pointer can be loaded from the index register, the bench can set it to 0x0000, 0x0001 and 0xFFFF directly. This makes wrap-around of pushes, pulls, adjusts, relative addresses and both transfers reachable in a few operations. The 0x00FF reset value keeps the push/pull sequence inside the first 256 bytes, which is the window that the bench's byte memory models.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [3:0] {
        OPC_PUSH     = 4'd0,
        OPC_PULL     = 4'd1,
        OPC_ADJUST   = 4'd2,
        OPC_REL_S    = 4'd3,
        OPC_REL_L    = 4'd4,
        OPC_RSP      = 4'd5,
        OPC_TO_IDX   = 4'd6,
        OPC_FROM_IDX = 4'd7
    } sp_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL_BUMP,
        ST_PULL_READ,
        ST_ADJUST,
        ST_REL_SHORT,
        ST_REL_LONG,
        ST_RSP,
        ST_TO_IDX,
        ST_FROM_IDX
    } sp_state_e;

endpackage

// File: rtl/sp_addr_gen.sv
module sp_addr_gen #(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int OFFW = 16
) (
    input  logic [AW-1:0]   sp,
    input  logic [DW-1:0]   imm,
    input  logic [OFFW-1:0] off,
    input  logic [AW-1:0]   idx,
    output logic [AW-1:0]   sp_dec,
    output logic [AW-1:0]   sp_inc,
    output logic [AW-1:0]   sp_adj,
    output logic [AW-1:0]   sp_lowfill,
    output logic [AW-1:0]   sp_from_idx,
    output logic [AW-1:0]   ea_short,
    output logic [AW-1:0]   ea_long
);
    localparam int             PAD = AW - DW;
    localparam logic [AW-1:0]  ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] off_ext;
    logic [AW-1:0] imm_sext;
    logic [AW-1:0] imm_zext;

    generate
        if (OFFW < AW) begin : g_off_pad
            assign off_ext = {{(AW-OFFW){1'b0}}, off};
        end else begin : g_off_full
            assign off_ext = off[AW-1:0];
        end
    endgenerate

    assign imm_sext    = {{PAD{imm[DW-1]}}, imm};
    assign imm_zext    = {{PAD{1'b0}}, imm};

    assign sp_dec      = sp - ONE;
    assign sp_inc      = sp + ONE;
    assign sp_adj      = sp + imm_sext;
    assign sp_lowfill  = {sp[AW-1:DW], {DW{1'b1}}};
    assign sp_from_idx = idx - ONE;
    assign ea_short    = sp + imm_zext;
    assign ea_long     = sp + off_ext;

endmodule

// File: rtl/sp_byte_sel.sv
module sp_byte_sel #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] acc,
    input  logic [AW-1:0] idx,
    output logic [DW-1:0] byte_out
);
    localparam int NB = AW / DW;

    logic [DW-1:0] parts [NB];

    generate
        for (genvar g = 0; g < NB; g++) begin : g_split
            assign parts[g] = idx[g*DW +: DW];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            2'd0:    byte_out = acc;
            2'd1:    byte_out = parts[NB-1];
            default: byte_out = parts[0];
        endcase
    end

endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit
    import sp_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            OFFW     = 16,
    parameter logic [AW-1:0] RESET_SP = 16'h00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] imm8,
    input  logic [OFFW-1:0] off16,
    input  logic [DW-1:0] acc_in,
    input  logic [AW-1:0] idx_in,
    output logic          op_ready,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          ea_valid,
    output logic          pull_valid,
    output logic [DW-1:0] pull_data,
    output logic [1:0]    pull_dst,
    output logic          idx_valid,
    output logic [AW-1:0] idx_out
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    sp_state_e     state, state_nx;
    logic [AW-1:0] sp;
    logic [DW-1:0] lat_imm;
    logic [OFFW-1:0] lat_off;
    logic [AW-1:0] lat_idx;
    logic [DW-1:0] lat_byte;
    logic [1:0]    lat_sel;
    logic [DW-1:0] sel_byte;
    logic          accept;

    logic [AW-1:0] sp_dec, sp_inc, sp_adj, sp_lowfill, sp_from_idx;
    logic [AW-1:0] ea_short, ea_long;

    sp_addr_gen #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_addr (
        .sp          (sp),
        .imm         (lat_imm),
        .off         (lat_off),
        .idx         (lat_idx),
        .sp_dec      (sp_dec),
        .sp_inc      (sp_inc),
        .sp_adj      (sp_adj),
        .sp_lowfill  (sp_lowfill),
        .sp_from_idx (sp_from_idx),
        .ea_short    (ea_short),
        .ea_long     (ea_long)
    );

    sp_byte_sel #(.AW(AW), .DW(DW)) u_sel (
        .sel      (reg_sel),
        .acc      (acc_in),
        .idx      (idx_in),
        .byte_out (sel_byte)
    );

    assign accept = (state == ST_IDLE) && op_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OPC_PUSH:     state_nx = ST_PUSH;
                        OPC_PULL:     state_nx = ST_PULL_BUMP;
                        OPC_ADJUST:   state_nx = ST_ADJUST;
                        OPC_REL_S:    state_nx = ST_REL_SHORT;
                        OPC_REL_L:    state_nx = ST_REL_LONG;
                        OPC_RSP:      state_nx = ST_RSP;
                        OPC_TO_IDX:   state_nx = ST_TO_IDX;
                        OPC_FROM_IDX: state_nx = ST_FROM_IDX;
                        default:      state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PULL_BUMP: state_nx = ST_PULL_READ;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Operand capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_imm  <= '0;
            lat_off  <= '0;
            lat_idx  <= '0;
            lat_byte <= '0;
            lat_sel  <= '0;
        end else if (accept) begin
            lat_imm  <= imm8;
            lat_off  <= off16;
            lat_idx  <= idx_in;
            lat_byte <= sel_byte;
            lat_sel  <= reg_sel;
        end
    end

    // Pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= RESET_SP;
        end else begin
            unique case (state)
                ST_PUSH:      sp <= sp_dec;
                ST_PULL_BUMP: sp <= sp_inc;
                ST_ADJUST:    sp <= sp_adj;
                ST_RSP:       sp <= sp_lowfill;
                ST_FROM_IDX:  sp <= sp_from_idx;
                default:      sp <= sp;
            endcase
        end
    end

    // Outputs
    always_comb begin
        op_ready   = 1'b0;
        mem_addr   = '0;
        mem_wr     = 1'b0;
        mem_rd     = 1'b0;
        mem_wdata  = '0;
        ea_valid   = 1'b0;
        pull_valid = 1'b0;
        pull_data  = '0;
        pull_dst   = '0;
        idx_valid  = 1'b0;
        idx_out    = '0;
        unique case (state)
            ST_IDLE: op_ready = 1'b1;
            ST_PUSH: begin
                mem_addr  = sp;
                mem_wr    = 1'b1;
                mem_wdata = lat_byte;
            end
            ST_PULL_READ: begin
                mem_addr   = sp;
                mem_rd     = 1'b1;
                pull_valid = 1'b1;
                pull_data  = mem_rdata;
                pull_dst   = lat_sel;
            end
            ST_REL_SHORT: begin
                mem_addr = ea_short;
                ea_valid = 1'b1;
            end
            ST_REL_LONG: begin
                mem_addr = ea_long;
                ea_valid = 1'b1;
            end
            ST_TO_IDX: begin
                idx_out   = sp_inc;
                idx_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign sp_out = sp;

    // Checks beside the pointer and output logic
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_out == $past(mem_addr) - ONE));

    assert_pull_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == $past(sp_out) + ONE));

    assert_rel_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> (sp_out == $past(sp_out)));

    assert_rsp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSP) |=> (sp_out[AW-1:DW] == $past(sp_out[AW-1:DW])) && (sp_out[DW-1:0] == {DW{1'b1}}));

    assert_xfer_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |=> (sp_out == $past(sp_out)));

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd, ea_valid, idx_valid, op_ready}));

endmodule

// File: tb/stack_addr_unit_test.sv
module stack_addr_unit_test;
    import sp_pkg::*;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [1:0]  reg_sel;
    logic [7:0]  imm8;
    logic [15:0] off16;
    logic [7:0]  acc_in;
    logic [15:0] idx_in;
    logic        op_ready;
    logic [15:0] sp_out;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        ea_valid, pull_valid, idx_valid;
    logic [7:0]  pull_data;
    logic [1:0]  pull_dst;
    logic [15:0] idx_out;

    stack_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .reg_sel(reg_sel), .imm8(imm8), .off16(off16), .acc_in(acc_in),
        .idx_in(idx_in), .op_ready(op_ready), .sp_out(sp_out),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ea_valid(ea_valid),
        .pull_valid(pull_valid), .pull_data(pull_data), .pull_dst(pull_dst),
        .idx_valid(idx_valid), .idx_out(idx_out)
    );

    // Byte memory over the low address byte
    logic [7:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    int total = 0;
    int bad   = 0;
    logic [15:0] msp;
    logic [7:0]  shadow [0:255];

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 relative, 3 index
        logic [15:0] a;
        logic [7:0]  d;
        logic [1:0]  dst;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected strobes as they appear
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (mem_wr || mem_rd || ea_valid || idx_valid)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R12", "unexpected strobe", {mem_wr, mem_rd, ea_valid, idx_valid}, 0);
            end else begin
                e = sb.pop_front();
                case (e.kind)
                    0: begin
                        chk(mem_wr && mem_addr == e.a, e.req, "push addr", mem_addr, e.a);
                        chk(mem_wdata == e.d, e.req, "push data", mem_wdata, e.d);
                    end
                    1: begin
                        chk(mem_rd && mem_addr == e.a, e.req, "pull addr", mem_addr, e.a);
                        chk(pull_valid && pull_data == e.d, e.req, "pull data", pull_data, e.d);
                        chk(pull_dst == e.dst, e.req, "pull dst", pull_dst, e.dst);
                    end
                    2: chk(ea_valid && mem_addr == e.a, e.req, "rel addr", mem_addr, e.a);
                    default: chk(idx_valid && idx_out == e.a, e.req, "idx value", idx_out, e.a);
                endcase
            end
        end
    end

    task automatic issue(input logic [3:0] code, input logic [1:0] sel,
                         input logic [7:0] imm, input logic [15:0] off,
                         input logic [15:0] idx, input logic [7:0] acc);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1; op_code = code; reg_sel = sel; imm8 = imm;
        off16 = off; idx_in = idx; acc_in = acc;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        while (!op_ready) @(negedge clk);
    endtask

    task automatic chk_sp(input string req);
        chk(sp_out == msp, req, "pointer", sp_out, msp);
    endtask

    task automatic do_push(input logic [1:0] sel, input logic [7:0] acc,
                           input logic [15:0] idx, input string req);
        logic [7:0] b;
        b = (sel == 2'd0) ? acc : (sel == 2'd1) ? idx[15:8] : idx[7:0];
        sb.push_back('{0, msp, b, 2'd0, req});
        shadow[msp[7:0]] = b;
        issue(OPC_PUSH, sel, 8'h00, 16'h0, idx, acc);
        msp = msp - 16'd1;
        chk_sp(req);
    endtask

    task automatic do_pull(input logic [1:0] sel, input logic [7:0] want, input string req);
        msp = msp + 16'd1;
        chk(shadow[msp[7:0]] == want, req, "lifo model", shadow[msp[7:0]], want);
        sb.push_back('{1, msp, want, sel, req});
        issue(OPC_PULL, sel, 8'h00, 16'h0, 16'h0, 8'h00);
        chk_sp(req);
    endtask

    task automatic do_adjust(input logic [7:0] imm, input string req);
        issue(OPC_ADJUST, 2'd0, imm, 16'h0, 16'h0, 8'h00);
        msp = msp + {{8{imm[7]}}, imm};
        chk_sp(req);
    endtask

    task automatic do_rel8(input logic [7:0] imm, input string req);
        sb.push_back('{2, msp + {8'h00, imm}, 8'h00, 2'd0, req});
        issue(OPC_REL_S, 2'd0, imm, 16'h0, 16'h0, 8'h00);
        chk_sp(req);
    endtask

    task automatic do_rel16(input logic [15:0] off, input string req);
        sb.push_back('{2, msp + off, 8'h00, 2'd0, req});
        issue(OPC_REL_L, 2'd0, 8'h00, off, 16'h0, 8'h00);
        chk_sp(req);
    endtask

    task automatic do_to_idx(input string req);
        sb.push_back('{3, msp + 16'd1, 8'h00, 2'd0, req});
        issue(OPC_TO_IDX, 2'd0, 8'h00, 16'h0, 16'h0, 8'h00);
        chk_sp(req);
    endtask

    task automatic do_from_idx(input logic [15:0] idx, input string req);
        issue(OPC_FROM_IDX, 2'd0, 8'h00, 16'h0, idx, 8'h00);
        msp = idx - 16'd1;
        chk_sp(req);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            shadow[i] = 8'h00;
        end
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; reg_sel = '0;
        imm8 = '0; off16 = '0; acc_in = '0; idx_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        msp = 16'h00FF;
        chk(sp_out == 16'h00FF, "R1", "reset pointer", sp_out, 16'h00FF);
        chk(op_ready == 1'b1, "R1", "reset ready", op_ready, 1);
        chk({mem_wr, mem_rd, ea_valid, idx_valid} == 4'b0, "R1", "reset strobes",
            {mem_wr, mem_rd, ea_valid, idx_valid}, 0);

        // R2 / R3 / R11: three pushes then three pulls
        do_push(2'd0, 8'h11, 16'hA5C3, "R2");
        do_push(2'd1, 8'h00, 16'hA5C3, "R2");
        do_push(2'd2, 8'h00, 16'hA5C3, "R2");
        do_pull(2'd2, 8'hC3, "R11");
        do_pull(2'd1, 8'hA5, "R3");
        do_pull(2'd0, 8'h11, "R11");
        chk(sp_out == 16'h00FF, "R11", "pointer restored", sp_out, 16'h00FF);

        // R4 adjust
        do_adjust(8'hF0, "R4");
        chk(sp_out == 16'h00EF, "R4", "open 16", sp_out, 16'h00EF);
        do_adjust(8'h10, "R4");

        // R5 / R6 relative
        do_rel8(8'h10, "R5");
        do_rel8(8'hFF, "R5");
        do_rel16(16'h1234, "R6");
        do_rel16(16'hFFFF, "R10");

        // R8 / R9 / R7 transfers and restore
        do_to_idx("R8");
        do_from_idx(16'h1234, "R9");
        issue(OPC_RSP, 2'd0, 8'h00, 16'h0, 16'h0, 8'h00);
        msp = 16'h12FF;
        chk_sp("R7");

        // R10 wrap around
        do_from_idx(16'h0001, "R9");
        do_push(2'd0, 8'h5A, 16'h0000, "R10");
        chk(sp_out == 16'hFFFF, "R10", "push wrap", sp_out, 16'hFFFF);
        do_pull(2'd0, 8'h5A, "R10");
        do_from_idx(16'h0000, "R10");
        do_to_idx("R10");
        do_adjust(8'h7F, "R10");
        issue(OPC_RSP, 2'd0, 8'h00, 16'h0, 16'h0, 8'h00);
        msp = 16'h00FF;
        chk_sp("R7");

        // R12: requests while busy are ignored
        shadow[8'h00] = 8'h77;
        mem[8'h00] = 8'h77;
        do_from_idx(16'h0000, "R9");
        sb.push_back('{1, 16'h0000, 8'h77, 2'd1, "R12"});
        @(negedge clk);
        op_valid = 1'b1; op_code = OPC_PULL; reg_sel = 2'd1;
        @(posedge clk);
        @(negedge clk);
        op_code = OPC_ADJUST; imm8 = 8'h40;
        chk(op_ready == 1'b0, "R12", "busy", op_ready, 0);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        msp = 16'h0000;
        chk_sp("R12");
        chk(op_ready == 1'b1, "R12", "ready again", op_ready, 1);

        // R12: undefined code has no effect
        issue(4'hF, 2'd0, 8'h33, 16'h0, 16'h0, 8'h00);
        @(negedge clk);
        chk_sp("R12");

        // R1: reset mid-run restores full value
        do_from_idx(16'h5556, "R9");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 16'h00FF, "R1", "reset again", sp_out, 16'h00FF);

        chk(sb.size() == 0, "R12", "pending strobes", sb.size(), 0);
        finish_run();
    end

endmodule